// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the single address reservation behind a load-linked / store-conditional pair for one core whose memory is shared with other agents. It watches every request the core makes to memory, each tagged as a plain load, a linked load, a plain store or a conditional store. It also watches the write addresses that other agents put on a set of snoop ports. A linked load arms the reservation with the word it read. Any write that could have touched that word before the matching conditional store breaks the reservation.

For every conditional store the block settles in the same cycle whether the write may reach memory. It raises the memory write enable only on success, and it returns a one-bit result (1 for success, 0 for failure) that the core writes into the store's register. A failure always completes at once and never stalls, so software can loop back and retry the sequence. An exception return or a pipeline flush drops the reservation through a dedicated clear input.

Top module: `llsc_reservation_monitor`

## Requirements
- R1: A linked load (req_kind 2'b01) with no clear and no same-cycle snoop to its word sets rsv_valid in the next cycle and records its word address; it never raises mem_we.
- R2: A conditional store (req_kind 2'b11) to the reserved word while rsv_valid is 1, with no clear and no snoop hit to that word in the same cycle, raises mem_we, sc_done and sc_result in that cycle.
- R3: A conditional store with rsv_valid at 0, or to a word other than the reserved one, raises sc_done with sc_result 0 and keeps mem_we at 0.
- R4: After any conditional store, whether it succeeds or fails, rsv_valid is 0 in the next cycle.
- R5: A valid write address on any snoop port that falls in the reserved word clears rsv_valid in the next cycle; a snooped write to another word leaves it set.
- R6: A plain store (req_kind 2'b10) always raises mem_we; to the reserved word it clears rsv_valid in the next cycle, to any other word it leaves it set.
- R7: clear_rsv clears rsv_valid in the next cycle, wins over a linked load in the same cycle, and makes a conditional store in the same cycle fail.
- R8: A new linked load replaces the held reservation, so a later conditional store succeeds only at the newer word.
- R9: Addresses are compared by word: bits [1:0] of every address are ignored.
- R10: A snoop hit on the reserved word in the same cycle as a conditional store makes that store fail, and a snoop hit on a linked load's own word in the same cycle leaves the reservation unarmed.
- R11: A plain load (req_kind 2'b00) keeps mem_we at 0 and leaves rsv_valid and the reserved word unchanged.
- R12: Out of reset rsv_valid is 0; sc_done is 1 only for a conditional store, and sc_result is 0 whenever sc_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core memory request present this cycle |
| req_kind | input | 2 | Request type: 00 load, 01 linked load, 10 store, 11 conditional store |
| req_addr | input | ADDR_W | Byte address of the request |
| snoop_valid | input | N_SNOOP | One valid bit per snoop port, for a write by another agent |
| snoop_addr | input | N_SNOOP*ADDR_W | Snooped write byte addresses, port k in bits [k*ADDR_W +: ADDR_W] |
| clear_rsv | input | 1 | Exception return or flush: drop the reservation |
| mem_we | output | 1 | Write enable toward memory for this request |
| sc_done | output | 1 | A conditional store completes this cycle |
| sc_result | output | 1 | Register value for the conditional store: 1 success, 0 failure |
| rsv_valid | output | 1 | Reservation currently armed |

## Verification
The bench goes after cases where the timing of the address matters. It checks a snoop in the same cycle as the conditional store, and a snoop in the same cycle as the linked load. A design that took the reservation from the register alone, without the same-cycle snoop, would let a store through after another agent had already written the word. The bench also checks byte addresses that differ only below the word boundary, and writes to the neighbouring word. A monitor that compared full byte addresses would fail a correct sequence, and one that compared too few bits would break the reservation for unrelated data. A second linked load to a new word, a failed store followed by a retry, and a clear that arrives together with a request show whether the update order and the rule that any conditional store clears the reservation were built as stated.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   // Request kinds presented by the core; the encoding is part of the port contract.
   typedef enum logic [1:0] {
      REQ_LOAD  = 2'b00,
      REQ_LINK  = 2'b01,
      REQ_STORE = 2'b10,
      REQ_COND  = 2'b11
   } req_kind_e;

endpackage

// File: rtl/llsc_word_match.sv
module llsc_word_match #(
   parameter int WORD_W = 30
) (
   input  logic [WORD_W-1:0] a_word,
   input  logic [WORD_W-1:0] b_word,
   output logic              equal
);

   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("llsc_word_match: WORD_W must be at least 1");
      end
   endgenerate

   assign equal = (a_word == b_word);

endmodule

// File: rtl/llsc_snoop_filter.sv
module llsc_snoop_filter #(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 2,
   parameter int N_SNOOP  = 2,
   localparam int WORD_W  = ADDR_W - OFFSET_W
) (
   input  logic [N_SNOOP-1:0]        snoop_valid,
   input  logic [N_SNOOP*ADDR_W-1:0] snoop_addr,
   input  logic [WORD_W-1:0]         rsv_word,
   input  logic [WORD_W-1:0]         link_word,
   output logic                      hit_rsv,
   output logic                      hit_link
);

   generate
      if (N_SNOOP < 1) begin : g_bad_ports
         $error("llsc_snoop_filter: N_SNOOP must be at least 1");
      end
   endgenerate

   logic [N_SNOOP-1:0] eq_rsv;
   logic [N_SNOOP-1:0] eq_link;

   generate
      for (genvar g = 0; g < N_SNOOP; g++) begin : g_port
         llsc_word_match #(.WORD_W(WORD_W)) u_cmp_rsv (
            .a_word (snoop_addr[g*ADDR_W + OFFSET_W +: WORD_W]),
            .b_word (rsv_word),
            .equal  (eq_rsv[g])
         );
         llsc_word_match #(.WORD_W(WORD_W)) u_cmp_link (
            .a_word (snoop_addr[g*ADDR_W + OFFSET_W +: WORD_W]),
            .b_word (link_word),
            .equal  (eq_link[g])
         );
      end
   endgenerate

   assign hit_rsv  = |(snoop_valid & eq_rsv);
   assign hit_link = |(snoop_valid & eq_link);

endmodule

// File: rtl/llsc_rsv_reg.sv
module llsc_rsv_reg #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              link_i,
   input  logic [WORD_W-1:0] link_word_i,
   input  logic              link_killed_i,
   input  logic              cond_i,
   input  logic              kill_i,
   output logic              rsv_valid_o,
   output logic [WORD_W-1:0] rsv_word_o
);

   // Update order: clear, then a new link, then anything that breaks the reservation.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsv_valid_o <= 1'b0;
         rsv_word_o  <= '0;
      end else if (clear_i) begin
         rsv_valid_o <= 1'b0;
      end else if (link_i) begin
         rsv_valid_o <= !link_killed_i;
         rsv_word_o  <= link_word_i;
      end else if (cond_i || kill_i) begin
         rsv_valid_o <= 1'b0;
      end
   end

   p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !rsv_valid_o);

   p_link_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (link_i && !clear_i && !link_killed_i) |=>
         (rsv_valid_o && rsv_word_o == $past(link_word_i)));

   p_cond_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_i && !link_i) |=> !rsv_valid_o);

   p_only_link_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsv_valid_o) |-> $past(link_i));

endmodule

// File: rtl/llsc_reservation_monitor.sv
module llsc_reservation_monitor
   import llsc_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 2,
   parameter int N_SNOOP  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [1:0]                req_kind,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [N_SNOOP-1:0]        snoop_valid,
   input  logic [N_SNOOP*ADDR_W-1:0] snoop_addr,
   input  logic                      clear_rsv,
   output logic                      mem_we,
   output logic                      sc_done,
   output logic                      sc_result,
   output logic                      rsv_valid
);

   localparam int WORD_W = ADDR_W - OFFSET_W;

   generate
      if (OFFSET_W < 0 || WORD_W < 1) begin : g_bad_geometry
         $error("llsc_reservation_monitor: OFFSET_W must leave a word address");
      end
   endgenerate

   req_kind_e           kind;
   logic                is_link, is_store, is_cond;
   logic [WORD_W-1:0]   req_word;
   logic [WORD_W-1:0]   rsv_word;
   logic                req_hits_rsv;
   logic                snoop_hit_rsv, snoop_hit_link;
   logic                own_store_hit;
   logic                cond_ok;

   assign kind     = req_kind_e'(req_kind);
   assign is_link  = req_valid && (kind == REQ_LINK);
   assign is_store = req_valid && (kind == REQ_STORE);
   assign is_cond  = req_valid && (kind == REQ_COND);
   assign req_word = req_addr[ADDR_W-1:OFFSET_W];

   llsc_word_match #(.WORD_W(WORD_W)) u_req_cmp (
      .a_word (req_word),
      .b_word (rsv_word),
      .equal  (req_hits_rsv)
   );

   llsc_snoop_filter #(
      .ADDR_W   (ADDR_W),
      .OFFSET_W (OFFSET_W),
      .N_SNOOP  (N_SNOOP)
   ) u_snoop (
      .snoop_valid (snoop_valid),
      .snoop_addr  (snoop_addr),
      .rsv_word    (rsv_word),
      .link_word   (req_word),
      .hit_rsv     (snoop_hit_rsv),
      .hit_link    (snoop_hit_link)
   );

   assign own_store_hit = is_store && req_hits_rsv;

   llsc_rsv_reg #(.WORD_W(WORD_W)) u_rsv (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear_i       (clear_rsv),
      .link_i        (is_link),
      .link_word_i   (req_word),
      .link_killed_i (snoop_hit_link),
      .cond_i        (is_cond),
      .kill_i        (snoop_hit_rsv || own_store_hit),
      .rsv_valid_o   (rsv_valid),
      .rsv_word_o    (rsv_word)
   );

   // Same-cycle snoop hits and clears count as having happened before the store.
   assign cond_ok   = is_cond && rsv_valid && req_hits_rsv && !snoop_hit_rsv && !clear_rsv;
   assign mem_we    = is_store || cond_ok;
   assign sc_done   = is_cond;
   assign sc_result = cond_ok;

   p_unarmed_fails_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b11 && !rsv_valid) |-> (!mem_we && !sc_result && sc_done));

   p_result_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_done |-> !sc_result);

   p_cond_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sc_done |-> (mem_we == sc_result));

   p_snoop_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_done && snoop_hit_rsv) |-> !mem_we);

   p_load_inert_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'b00 && !clear_rsv && snoop_valid == '0)
         |=> ($stable(rsv_valid) && $stable(rsv_word)));

   p_load_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_kind == 2'b00 || req_kind == 2'b01)) |-> !mem_we);

   p_snoop_breaks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_hit_rsv && !is_link) |=> !rsv_valid);

endmodule

// File: tb/llsc_reservation_monitor_bench.sv
module llsc_reservation_monitor_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int NS = 2;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic [1:0]        req_kind;
   logic [AW-1:0]     req_addr;
   logic [NS-1:0]     snoop_valid;
   logic [NS*AW-1:0]  snoop_addr;
   logic              clear_rsv;
   logic              mem_we, sc_done, sc_result, rsv_valid;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic ob_we, ob_done, ob_res;

   always #(CLK_PERIOD/2) clk = ~clk;

   llsc_reservation_monitor #(.ADDR_W(AW), .OFFSET_W(2), .N_SNOOP(NS)) u_llsc_reservation_monitor (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_kind (req_kind),
      .req_addr (req_addr), .snoop_valid (snoop_valid), .snoop_addr (snoop_addr),
      .clear_rsv (clear_rsv), .mem_we (mem_we), .sc_done (sc_done),
      .sc_result (sc_result), .rsv_valid (rsv_valid)
   );

   localparam logic [1:0] K_LOAD = 2'b00, K_LINK = 2'b01, K_STORE = 2'b10, K_COND = 2'b11;

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs at the falling edge and sample the combinational outputs.
   task automatic drive(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                        input logic s0v, input logic [AW-1:0] s0a,
                        input logic s1v, input logic [AW-1:0] s1a, input logic clr);
      @(negedge clk);
      req_valid   = v;
      req_kind    = k;
      req_addr    = a;
      snoop_valid = {s1v, s0v};
      snoop_addr  = {s1a, s0a};
      clear_rsv   = clr;
      #1;
      ob_we   = mem_we;
      ob_done = sc_done;
      ob_res  = sc_result;
   endtask

   task automatic req(input logic [1:0] k, input logic [AW-1:0] a);
      drive(1'b1, k, a, 1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic idle();
      drive(1'b0, K_LOAD, '0, 1'b0, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic t_reset();
      idle();
      chk("R12 reset rsv_valid", rsv_valid, 1'b0);
      chk("R12 reset sc_done", ob_done, 1'b0);
      chk("R12 reset sc_result", ob_res, 1'b0);
   endtask

   task automatic t_basic();
      req(K_LINK, 32'h100);
      chk("R1 link no write", ob_we, 1'b0);
      chk("R12 link no sc_done", ob_done, 1'b0);
      idle();
      chk("R1 link arms", rsv_valid, 1'b1);
      req(K_COND, 32'h100);
      chk("R2 cond we", ob_we, 1'b1);
      chk("R2 cond done", ob_done, 1'b1);
      chk("R2 cond result", ob_res, 1'b1);
      idle();
      chk("R4 success clears", rsv_valid, 1'b0);
      req(K_COND, 32'h100);
      chk("R3 unarmed no we", ob_we, 1'b0);
      chk("R3 unarmed done", ob_done, 1'b1);
      chk("R3 unarmed result", ob_res, 1'b0);
   endtask

   task automatic t_mismatch();
      req(K_LINK, 32'h200);
      req(K_COND, 32'h204);
      chk("R3 mismatch no we", ob_we, 1'b0);
      chk("R3 mismatch result", ob_res, 1'b0);
      idle();
      chk("R4 failure clears", rsv_valid, 1'b0);
   endtask

   task automatic t_offset();
      req(K_LINK, 32'h303);
      req(K_COND, 32'h300);
      chk("R9 offset ignored we", ob_we, 1'b1);
      chk("R9 offset ignored result", ob_res, 1'b1);
   endtask

   task automatic t_snoop();
      req(K_LINK, 32'h400);
      drive(1'b0, K_LOAD, '0, 1'b0, '0, 1'b1, 32'h404, 1'b0);
      idle();
      chk("R5 other word snoop keeps", rsv_valid, 1'b1);
      drive(1'b0, K_LOAD, '0, 1'b0, '0, 1'b1, 32'h402, 1'b0);
      idle();
      chk("R5 snoop hit clears", rsv_valid, 1'b0);
      req(K_COND, 32'h400);
      chk("R5 cond after snoop fails", ob_res, 1'b0);
   endtask

   task automatic t_own_store();
      req(K_LINK, 32'h500);
      req(K_STORE, 32'h504);
      chk("R6 store writes", ob_we, 1'b1);
      idle();
      chk("R6 other word store keeps", rsv_valid, 1'b1);
      req(K_STORE, 32'h501);
      chk("R6 store writes to reserved", ob_we, 1'b1);
      idle();
      chk("R6 own store clears", rsv_valid, 1'b0);
   endtask

   task automatic t_flush();
      req(K_LINK, 32'h600);
      drive(1'b0, K_LOAD, '0, 1'b0, '0, 1'b0, '0, 1'b1);
      idle();
      chk("R7 clear drops", rsv_valid, 1'b0);
      req(K_LINK, 32'h600);
      drive(1'b1, K_COND, 32'h600, 1'b0, '0, 1'b0, '0, 1'b1);
      chk("R7 clear fails cond we", ob_we, 1'b0);
      chk("R7 clear fails cond result", ob_res, 1'b0);
      drive(1'b1, K_LINK, 32'h610, 1'b0, '0, 1'b0, '0, 1'b1);
      idle();
      chk("R7 clear beats link", rsv_valid, 1'b0);
   endtask

   task automatic t_replace();
      req(K_LINK, 32'h700);
      req(K_LINK, 32'h800);
      req(K_COND, 32'h800);
      chk("R8 newer word succeeds", ob_res, 1'b1);
      req(K_LINK, 32'h700);
      req(K_LINK, 32'h800);
      req(K_COND, 32'h700);
      chk("R8 older word fails", ob_res, 1'b0);
      chk("R8 older word no we", ob_we, 1'b0);
   endtask

   task automatic t_same_cycle();
      req(K_LINK, 32'h900);
      drive(1'b1, K_COND, 32'h900, 1'b1, 32'h901, 1'b0, '0, 1'b0);
      chk("R10 snoop with cond no we", ob_we, 1'b0);
      chk("R10 snoop with cond result", ob_res, 1'b0);
      drive(1'b1, K_LINK, 32'h980, 1'b0, '0, 1'b1, 32'h983, 1'b0);
      idle();
      chk("R10 snoop with link unarmed", rsv_valid, 1'b0);
   endtask

   task automatic t_load();
      req(K_LINK, 32'hA00);
      req(K_LOAD, 32'hA00);
      chk("R11 load no write", ob_we, 1'b0);
      chk("R12 load no sc_done", ob_done, 1'b0);
      req(K_LOAD, 32'hB00);
      idle();
      chk("R11 load keeps reservation", rsv_valid, 1'b1);
      req(K_COND, 32'hA00);
      chk("R11 reserved word unchanged", ob_res, 1'b1);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0; req_kind = K_LOAD; req_addr = '0;
      snoop_valid = '0; snoop_addr = '0; clear_rsv = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mismatch();
      t_offset();
      t_snoop();
      t_own_store();
      t_flush();
      t_replace();
      t_same_cycle();
      t_load();
      idle();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule